// File: doc/BRIEF.md
# Interrupt Event Collector with Sticky Flags and Set/Clear Mask

This block sits beside an I2C controller core and turns its one-cycle event pulses into a single level-sensitive interrupt line. Each event source owns a sticky flag that is set by its pulse and stays set until software clears it by writing a one to its position in the flag register.

Each source also has a mask bit, and only unmasked flags reach the interrupt output. Software cannot write the mask register directly. It changes the mask through two write-only strobe registers: ones written to one of them unmask sources, and ones written to the other mask them. The current mask reads back from a read-only register.

The register port is a plain single-cycle write strobe with a combinational read path addressed by byte offset. No bus fabric and no protocol engine are part of the block.

Top module: `irq_event_collector`

## Requirements
- R1: After reset, every flag is zero, every source is masked (mask reads zero) and `irq_out` is low.
- R2: A one on `evt_pulse[i]` at a clock edge sets flag i. The flag reads back as bit i of the flag register at offset 0x10, and it stays set until software clears it.
- R3: A write to offset 0x10 clears each flag whose bit in `bus_wdata` is one. Flags whose written bit is zero are left unchanged.
- R4: When an event pulse and a clearing write to the same flag occur at the same edge, the flag is set after that edge.
- R5: A write to offset 0x24 unmasks every source whose bit in `bus_wdata` is one. Zero bits leave those mask bits unchanged, and bits at or above the source count are ignored.
- R6: A write to offset 0x28 masks every source whose bit in `bus_wdata` is one. Zero bits leave those mask bits unchanged.
- R7: The mask reads back at offset 0x20, with bit i set meaning source i is unmasked. Writes to offset 0x20 have no effect.
- R8: Reads of offsets 0x24 and 0x28, and of any unmapped offset, return zero. Writes to unmapped offsets have no effect. Register bits at or above the source count read zero.
- R9: `irq_out` is high exactly when at least one flag is set and its source is unmasked.
- R10: Writing all ones to offset 0x28 and then all ones to offset 0x10 leaves every source masked, every flag cleared and `irq_out` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte offset for both reads and writes |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for `bus_addr` |
| evt_pulse | input | NSRC | One-cycle event pulses from the core, one per source |
| irq_out | output | 1 | Interrupt request, level |

## Verification
A flag or mask bit that fails to set or clear shows on the port one clock after the offending edge. It appears both in the readback at 0x10 or 0x20 and as a wrong level on `irq_out`. A wrong priority between an event and a clear is visible one cycle later as a flag that reads zero when it should read one. A decode fault, where a write lands on the wrong register or a write-only register leaks its value into a read, shows in the next read of the neighbouring offset. The vector table therefore follows every write with a read of a chosen offset and a check of `irq_out` in the same cycle.

// File: rtl/irq_regs_pkg.sv
package irq_regs_pkg;
    localparam logic [11:0] OFS_FLAGS   = 12'h010;
    localparam logic [11:0] OFS_MASK    = 12'h020;
    localparam logic [11:0] OFS_UNMASK  = 12'h024;
    localparam logic [11:0] OFS_REMASK  = 12'h028;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_FLAGS,
        SEL_MASK,
        SEL_UNMASK,
        SEL_REMASK
    } reg_sel_e;
endpackage

// File: rtl/irq_addr_decode.sv
module irq_addr_decode
    import irq_regs_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    always_comb begin
        if (addr == ADDR_W'(OFS_FLAGS))       sel = SEL_FLAGS;
        else if (addr == ADDR_W'(OFS_MASK))   sel = SEL_MASK;
        else if (addr == ADDR_W'(OFS_UNMASK)) sel = SEL_UNMASK;
        else if (addr == ADDR_W'(OFS_REMASK)) sel = SEL_REMASK;
        else                                  sel = SEL_NONE;
    end
endmodule

// File: rtl/irq_flag_bit.sv
module irq_flag_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic clr,
    input  logic unmask,
    input  logic remask,
    output logic flag_q,
    output logic open_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            open_q <= 1'b0;
        end else begin
            flag_q <= (flag_q & ~clr) | evt;
            open_q <= (open_q | unmask) & ~remask;
        end
    end

    // R2 R4
    sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> flag_q);

    // R3
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !evt) |=> !flag_q);

    // R5
    unmask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unmask |=> open_q);

    // R6
    remask_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        remask |=> !open_q);
endmodule

// File: rtl/irq_event_collector.sv
module irq_event_collector
    import irq_regs_pkg::*;
#(
    parameter int NSRC   = 10,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NSRC-1:0]   evt_pulse,
    output logic              irq_out
);
    localparam int PAD_W = DATA_W - NSRC;

    reg_sel_e        sel;
    logic [NSRC-1:0] wbits;
    logic [NSRC-1:0] flag_vec;
    logic [NSRC-1:0] open_vec;
    logic            wr_flags;
    logic            wr_unmask;
    logic            wr_remask;

    irq_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    assign wbits     = bus_wdata[NSRC-1:0];
    assign wr_flags  = bus_wr && (sel == SEL_FLAGS);
    assign wr_unmask = bus_wr && (sel == SEL_UNMASK);
    assign wr_remask = bus_wr && (sel == SEL_REMASK);

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        irq_flag_bit u_bit (
            .clk    (clk),
            .rst_n  (rst_n),
            .evt    (evt_pulse[i]),
            .clr    (wr_flags & wbits[i]),
            .unmask (wr_unmask & wbits[i]),
            .remask (wr_remask & wbits[i]),
            .flag_q (flag_vec[i]),
            .open_q (open_vec[i])
        );
    end

    always_comb begin
        unique case (sel)
            SEL_FLAGS: bus_rdata = {{PAD_W{1'b0}}, flag_vec};
            SEL_MASK:  bus_rdata = {{PAD_W{1'b0}}, open_vec};
            default:   bus_rdata = '0;
        endcase
    end

    assign irq_out = |(flag_vec & open_vec);

    // R7
    mask_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel == SEL_MASK) |=> $stable(open_vec));

    // R9
    irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_out) |-> $past((|evt_pulse) || wr_unmask));
endmodule

// File: tb/sim_irq_event_collector.sv
module sim_irq_event_collector;
    localparam int NSRC   = 10;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 14;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [NSRC-1:0]   evt;
        logic [ADDR_W-1:0] raddr;
        logic [DATA_W-1:0] exp_rd;
        logic              exp_irq;
        logic [3:0]        req;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 8'h00, 32'h0,        10'h005, 8'h10, 32'h005, 1'b0, 4'd2},  // R2
        '{1'b0, 8'h00, 32'h0,        10'h000, 8'h10, 32'h005, 1'b0, 4'd2},  // R2 sticky
        '{1'b1, 8'h24, 32'h001,      10'h000, 8'h20, 32'h001, 1'b1, 4'd5},  // R5 R9
        '{1'b1, 8'h24, 32'h000,      10'h000, 8'h20, 32'h001, 1'b1, 4'd5},  // R5 zeros
        '{1'b1, 8'h10, 32'h004,      10'h000, 8'h10, 32'h001, 1'b1, 4'd3},  // R3
        '{1'b1, 8'h28, 32'h000,      10'h000, 8'h20, 32'h001, 1'b1, 4'd6},  // R6 zeros
        '{1'b1, 8'h28, 32'h001,      10'h000, 8'h20, 32'h000, 1'b0, 4'd6},  // R6
        '{1'b1, 8'h20, 32'h3FF,      10'h000, 8'h20, 32'h000, 1'b0, 4'd7},  // R7
        '{1'b1, 8'h24, 32'h300,      10'h000, 8'h24, 32'h000, 1'b0, 4'd8},  // R8
        '{1'b0, 8'h00, 32'h0,        10'h200, 8'h28, 32'h000, 1'b1, 4'd9},  // R9 R8
        '{1'b1, 8'h10, 32'h200,      10'h200, 8'h10, 32'h201, 1'b1, 4'd4},  // R4
        '{1'b1, 8'h10, 32'h3FF,      10'h000, 8'h10, 32'h000, 1'b0, 4'd3},  // R3
        '{1'b1, 8'h14, 32'h3FF,      10'h000, 8'h20, 32'h300, 1'b0, 4'd8},  // R8 unmapped
        '{1'b1, 8'h24, 32'hFFFFFFFF, 10'h000, 8'h20, 32'h3FF, 1'b0, 4'd5}   // R5 high bits
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic [NSRC-1:0]   evt_pulse = '0;
    logic              irq_out;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_event_collector #(.NSRC(NSRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_pulse(evt_pulse),
        .irq_out(irq_out)
    );

    task automatic check_rd(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] exp,
                            input string req);
        bus_addr = a;
        #1;
        tests++;
        if (bus_rdata !== exp) begin
            fails++;
            $display("FAIL %s read 0x%0h: got 0x%0h expected 0x%0h", req, a, bus_rdata, exp);
        end
    endtask

    task automatic check_irq(input logic exp, input string req);
        tests++;
        if (irq_out !== exp) begin
            fails++;
            $display("FAIL %s irq_out: got %0b expected %0b", req, irq_out, exp);
        end
    endtask

    task automatic step(input logic wr, input logic [ADDR_W-1:0] a,
                        input logic [DATA_W-1:0] d, input logic [NSRC-1:0] e);
        @(negedge clk);
        bus_wr = wr; bus_addr = a; bus_wdata = d; evt_pulse = e;
        @(posedge clk);
        #1;
        bus_wr = 1'b0; evt_pulse = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check_rd(8'h10, 32'h0, "R1");
        check_rd(8'h20, 32'h0, "R1");
        check_irq(1'b0, "R1");
        rst_n = 1'b1;

        for (int k = 0; k < NVEC; k++) begin
            step(VECS[k].wr, VECS[k].addr, VECS[k].wdata, VECS[k].evt);
            check_rd(VECS[k].raddr, VECS[k].exp_rd, $sformatf("R%0d vec%0d", VECS[k].req, k));
            check_irq(VECS[k].exp_irq, $sformatf("R%0d vec%0d", VECS[k].req, k));
        end

        // R10: all sources firing and unmasked, then all-ones remask and clear
        step(1'b0, 8'h00, 32'h0, 10'h3FF);
        check_irq(1'b1, "R10 pre");
        step(1'b1, 8'h28, 32'hFFFFFFFF, '0);
        check_rd(8'h20, 32'h0, "R10 mask");
        check_irq(1'b0, "R10");
        step(1'b1, 8'h10, 32'hFFFFFFFF, '0);
        check_rd(8'h10, 32'h0, "R10 flags");
        check_irq(1'b0, "R10");

        // R9: flag set while masked, then unmasked later raises irq
        step(1'b0, 8'h00, 32'h0, 10'h040);
        check_irq(1'b0, "R9 masked");
        step(1'b1, 8'h24, 32'h040, '0);
        check_irq(1'b1, "R9 unmasked");

        // R1: reset in mid-run returns to the reset state
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check_rd(8'h10, 32'h0, "R1 rerun");
        check_rd(8'h20, 32'h0, "R1 rerun");
        check_irq(1'b0, "R1 rerun");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule